// File: doc/BRIEF.md
# Banked Bit-Addressable Data Memory

This block holds the 128-byte internal data RAM of an 8-bit microcontroller core, together with the program status word and the stack pointer. The RAM can be reached in several ways. A direct byte port takes a 7-bit address. A register port takes a 3-bit register number and adds the base of the bank currently selected in the status word. A single-bit port modifies one bit of the bit-addressable window in one cycle. Push and pop ports move bytes through the stack pointer.

All reads are synchronous. Each read output is registered and shows the memory contents from before any write in the same cycle. Storage, the status word and the stack pointer are cleared or initialised by an active-low asynchronous reset. Several write sources may fire in the same cycle. They are merged in a fixed order, and the single-bit operation is applied last.

Top module: `iram_core`

## Requirements
- R1: After reset the stack pointer is 07H, the status word is 00H, every RAM byte is 00H and every read output is 0.
- R2: A byte write lands at the next clock edge. A byte read returns its data one cycle after the address is applied, and a read of the byte being written in the same cycle returns the old value.
- R3: Register number r maps to byte address 8*b + r, where b = {status bit 4, status bit 3}. Both register writes and the register read output use this address.
- R4: A status-word write stores bits 7..2. Bit 1 always reads 0, and bit 0 is not changed by a status-word write.
- R5: Each accumulator write sets status bit 0 to the XOR of the 8 accumulator bits.
- R6: Bit address a selects bit a[2:0] of byte 20H + a[6:3]. bit_rd_o returns that bit, registered, before any same-cycle change. For example, 67H is bit 7 of byte 2CH.
- R7: Bit operation codes are: 00 = set, 01 = clear, 10 = AND with bit_val_i, 11 = OR with bit_val_i. Only the addressed bit changes.
- R8: A push first increments the stack pointer and then writes at the new value. A pop outputs the byte at the stack pointer and then decrements it. A push and a pop in the same cycle change nothing.
- R9: The stack pointer wraps from 7FH to 00H on a push and from 00H to 7FH on a pop.
- R10: Writes to the same byte in one cycle are applied in the order byte port, register port, push, with the later one winning. A bit operation is then applied on top of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 7 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| rd_addr_i | input | 7 | Byte read address |
| rd_data_o | output | 8 | Byte read data, one cycle later |
| reg_wr_en_i | input | 1 | Register write enable |
| reg_num_i | input | 3 | Register number for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, one cycle later |
| bit_en_i | input | 1 | Bit operation enable |
| bit_op_i | input | 2 | Bit operation code |
| bit_addr_i | input | 7 | Bit address for operation and read |
| bit_val_i | input | 1 | Operand for AND/OR |
| bit_rd_o | output | 1 | Addressed bit, one cycle later |
| psw_wr_en_i | input | 1 | Status word write enable |
| psw_wdata_i | input | 8 | Status word write data |
| acc_wr_en_i | input | 1 | Accumulator write strobe |
| acc_data_i | input | 8 | Accumulator value being written |
| psw_o | output | 8 | Status word |
| push_i | input | 1 | Push request |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 8 | Byte popped, held until next pop |
| sp_o | output | 7 | Stack pointer |

## Verification
The collision of interest is a byte-level write and a single-bit operation landing on the same byte of the bit window in one cycle. The bench provokes it by driving a byte write to 25H and a set or clear of one of that byte's bits on the same edge. It then reads 25H back and expects the written byte with only the addressed bit forced. Register-against-byte and push-against-byte collisions on one address are driven the same way, and the bench checks that the later source in the merge order owns the byte.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    BIT_SET = 2'b00,
    BIT_CLR = 2'b01,
    BIT_AND = 2'b10,
    BIT_OR  = 2'b11
  } bit_op_e;

  function automatic logic bit_apply(bit_op_e op, logic cur, logic val);
    case (op)
      BIT_SET: bit_apply = 1'b1;
      BIT_CLR: bit_apply = 1'b0;
      BIT_AND: bit_apply = cur & val;
      default: bit_apply = cur | val;
    endcase
  endfunction
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map #(
  parameter int AW      = iram_pkg::ADDR_W,
  parameter int DW      = iram_pkg::DATA_W,
  parameter int BANK_W  = 2,
  parameter int RN_W    = 3,
  parameter logic [AW-1:0] BIT_BASE = 7'h20
) (
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [RN_W-1:0]       reg_num_i,
  input  logic [AW-1:0]         bit_addr_i,
  output logic [AW-1:0]         reg_addr_o,
  output logic [AW-1:0]         bit_byte_o,
  output logic [$clog2(DW)-1:0] bit_pos_o
);
  localparam int POS_W = $clog2(DW);

  assign reg_addr_o = AW'({bank_i, reg_num_i});
  assign bit_byte_o = BIT_BASE + AW'(bit_addr_i[AW-1:POS_W]);
  assign bit_pos_o  = bit_addr_i[POS_W-1:0];
endmodule

// File: rtl/iram_psw.sv
module iram_psw #(
  parameter int DW      = iram_pkg::DATA_W,
  parameter int BANK_W  = 2,
  parameter int BANK_LO = 3,
  parameter int PAR_BIT = 0,
  parameter int RSV_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psw_wr_en_i,
  input  logic [DW-1:0]     psw_wdata_i,
  input  logic              acc_wr_en_i,
  input  logic [DW-1:0]     acc_data_i,
  output logic [DW-1:0]     psw_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [DW-1:0] psw_q, psw_d;

  always_comb begin
    psw_d = psw_q;
    if (psw_wr_en_i) begin
      for (int i = 0; i < DW; i++)
        if (i != PAR_BIT) psw_d[i] = psw_wdata_i[i];
    end
    psw_d[RSV_BIT] = 1'b0;
    if (acc_wr_en_i) psw_d[PAR_BIT] = ^acc_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) psw_q <= '0;
    else         psw_q <= psw_d;

  assign psw_o  = psw_q;
  assign bank_o = psw_q[BANK_LO +: BANK_W];

  // R5
  parity_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr_en_i |=> psw_o[PAR_BIT] == ^$past(acc_data_i));
  // R4
  parity_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr_en_i && !acc_wr_en_i) |=> psw_o[PAR_BIT] == $past(psw_o[PAR_BIT]));
  // R4
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_wr_en_i |=> !psw_o[RSV_BIT]);
endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
  parameter int AW = iram_pkg::ADDR_W,
  parameter logic [AW-1:0] SP_RST = 7'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_go_o,
  output logic          pop_go_o,
  output logic [AW-1:0] push_addr_o,
  output logic [AW-1:0] sp_o
);
  logic [AW-1:0] sp_q, sp_d;

  assign push_go_o   = push_i & ~pop_i;
  assign pop_go_o    = pop_i & ~push_i;
  assign push_addr_o = sp_q + 1'b1;

  always_comb begin
    sp_d = sp_q;
    if (push_go_o)     sp_d = push_addr_o;
    else if (pop_go_o) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sp_q <= SP_RST;
    else         sp_q <= sp_d;

  assign sp_o = sp_q;

  // R8 R9
  sp_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> sp_o == AW'($past(sp_o) + 1'b1));
  // R8 R9
  sp_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_o == AW'($past(sp_o) - 1'b1));
  // R8
  sp_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(sp_o));
endmodule

// File: rtl/iram_array.sv
module iram_array
  import iram_pkg::*;
#(
  parameter int AW = iram_pkg::ADDR_W,
  parameter int DW = iram_pkg::DATA_W,
  parameter int NP = 3,
  parameter int NR = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NP-1:0]                wr_en_i,
  input  logic [NP-1:0][AW-1:0]        wr_addr_i,
  input  logic [NP-1:0][DW-1:0]        wr_data_i,
  input  logic                         bit_en_i,
  input  bit_op_e                      bit_op_i,
  input  logic                         bit_val_i,
  input  logic [AW-1:0]                bit_byte_i,
  input  logic [$clog2(DW)-1:0]        bit_pos_i,
  input  logic [NR-1:0]                rd_en_i,
  input  logic [NR-1:0][AW-1:0]        rd_addr_i,
  output logic [NR-1:0][DW-1:0]        rd_data_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  // later write ports override earlier ones; bit op goes last
  always_comb begin
    for (int b = 0; b < DEPTH; b++) begin
      mem_d[b] = mem_q[b];
      for (int p = 0; p < NP; p++)
        if (wr_en_i[p] && wr_addr_i[p] == AW'(b)) mem_d[b] = wr_data_i[p];
      if (bit_en_i && bit_byte_i == AW'(b))
        mem_d[b][bit_pos_i] = bit_apply(bit_op_i, mem_d[b][bit_pos_i], bit_val_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int b = 0; b < DEPTH; b++) mem_q[b] <= '0;
    end else begin
      for (int b = 0; b < DEPTH; b++) mem_q[b] <= mem_d[b];
    end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)         rd_q <= '0;
      else if (rd_en_i[r]) rd_q <= mem_q[rd_addr_i[r]];
    assign rd_data_o[r] = rd_q;
  end

  // R7
  bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && bit_op_i == BIT_SET) |=> mem_q[$past(bit_byte_i)][$past(bit_pos_i)]);
  // R7
  bit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && bit_op_i == BIT_CLR) |=> !mem_q[$past(bit_byte_i)][$past(bit_pos_i)]);
endmodule

// File: rtl/iram_core.sv
module iram_core
  import iram_pkg::*;
#(
  parameter int AW     = iram_pkg::ADDR_W,
  parameter int DW     = iram_pkg::DATA_W,
  parameter int RN_W   = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              reg_wr_en_i,
  input  logic [RN_W-1:0]   reg_num_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              bit_en_i,
  input  logic [1:0]        bit_op_i,
  input  logic [AW-1:0]     bit_addr_i,
  input  logic              bit_val_i,
  output logic              bit_rd_o,
  input  logic              psw_wr_en_i,
  input  logic [DW-1:0]     psw_wdata_i,
  input  logic              acc_wr_en_i,
  input  logic [DW-1:0]     acc_data_i,
  output logic [DW-1:0]     psw_o,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  output logic [DW-1:0]     pop_data_o,
  output logic [AW-1:0]     sp_o
);
  localparam int POS_W = $clog2(DW);
  localparam int NP = 3;
  localparam int NR = 4;

  logic [BANK_W-1:0] bank;
  logic [AW-1:0]     reg_addr, bit_byte, push_addr;
  logic [POS_W-1:0]  bit_pos, bit_pos_q;
  logic              push_go, pop_go;

  logic [NP-1:0]          wen;
  logic [NP-1:0][AW-1:0]  waddr;
  logic [NP-1:0][DW-1:0]  wdata;
  logic [NR-1:0]          ren;
  logic [NR-1:0][AW-1:0]  raddr;
  logic [NR-1:0][DW-1:0]  rdata;

  iram_psw #(.DW(DW), .BANK_W(BANK_W)) i_psw (
    .clk_i, .rst_ni, .psw_wr_en_i, .psw_wdata_i, .acc_wr_en_i, .acc_data_i,
    .psw_o, .bank_o(bank)
  );

  iram_sp #(.AW(AW)) i_sp (
    .clk_i, .rst_ni, .push_i, .pop_i,
    .push_go_o(push_go), .pop_go_o(pop_go), .push_addr_o(push_addr), .sp_o
  );

  iram_addr_map #(.AW(AW), .DW(DW), .BANK_W(BANK_W), .RN_W(RN_W)) i_map (
    .bank_i(bank), .reg_num_i, .bit_addr_i,
    .reg_addr_o(reg_addr), .bit_byte_o(bit_byte), .bit_pos_o(bit_pos)
  );

  // merge order: byte, register, push
  assign wen   = {push_go,   reg_wr_en_i, wr_en_i};
  assign waddr = {push_addr, reg_addr,    wr_addr_i};
  assign wdata = {push_data_i, reg_wdata_i, wr_data_i};

  assign ren   = {pop_go, 1'b1, 1'b1, 1'b1};
  assign raddr = {sp_o, bit_byte, reg_addr, rd_addr_i};

  iram_array #(.AW(AW), .DW(DW), .NP(NP), .NR(NR)) i_array (
    .clk_i, .rst_ni,
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .bit_en_i, .bit_op_i(bit_op_e'(bit_op_i)), .bit_val_i,
    .bit_byte_i(bit_byte), .bit_pos_i(bit_pos),
    .rd_en_i(ren), .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bit_pos_q <= '0;
    else         bit_pos_q <= bit_pos;

  assign rd_data_o   = rdata[0];
  assign reg_rdata_o = rdata[1];
  assign bit_rd_o    = rdata[2][bit_pos_q];
  assign pop_data_o  = rdata[3];

  // R8
  pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !push_i) |=> $stable(pop_data_o));
endmodule

// File: tb/test_iram_core.sv
module test_iram_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 0, reg_wr_en_i = 0, bit_en_i = 0, bit_val_i = 0;
  logic [6:0] wr_addr_i = 0, rd_addr_i = 0, bit_addr_i = 0;
  logic [7:0] wr_data_i = 0, reg_wdata_i = 0, psw_wdata_i = 0, acc_data_i = 0, push_data_i = 0;
  logic [2:0] reg_num_i = 0;
  logic [1:0] bit_op_i = 0;
  logic       psw_wr_en_i = 0, acc_wr_en_i = 0, push_i = 0, pop_i = 0;
  logic [7:0] rd_data_o, reg_rdata_o, psw_o, pop_data_o;
  logic       bit_rd_o;
  logic [6:0] sp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  iram_core i_iram_core (.*);

  // {bank[20:19], reg[18:16], data[15:8], expected byte address[7:0]}
  localparam logic [20:0] VEC [8] = '{
    {2'd0, 3'd0, 8'h11, 8'h00}, {2'd0, 3'd7, 8'h22, 8'h07},
    {2'd1, 3'd0, 8'h33, 8'h08}, {2'd1, 3'd5, 8'h44, 8'h0D},
    {2'd2, 3'd1, 8'h55, 8'h11}, {2'd2, 3'd6, 8'h66, 8'h16},
    {2'd3, 3'd0, 8'h77, 8'h18}, {2'd3, 3'd7, 8'h88, 8'h1F}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; reg_wr_en_i = 0; bit_en_i = 0; psw_wr_en_i = 0;
    acc_wr_en_i = 0; push_i = 0; pop_i = 0;
  endtask

  task automatic wbyte(logic [6:0] a, logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d; step(); idle();
  endtask

  task automatic rbyte(logic [6:0] a, output logic [7:0] d);
    rd_addr_i = a; step(); d = rd_data_o;
  endtask

  task automatic bitop(logic [1:0] op, logic [6:0] a, logic v);
    bit_en_i = 1; bit_op_i = op; bit_addr_i = a; bit_val_i = v; step(); idle();
  endtask

  task automatic pswwr(logic [7:0] d);
    psw_wr_en_i = 1; psw_wdata_i = d; step(); idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 sp", {1'b0, sp_o}, 8'h07);
    chk("R1 psw", psw_o, 8'h00);
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 pop", pop_data_o, 8'h00);
    @(negedge clk_i); rst_ni = 1;
    rbyte(7'h55, d); chk("R1 ram cleared", d, 8'h00);

    // R2 read-before-write and latency
    wr_en_i = 1; wr_addr_i = 7'h40; wr_data_i = 8'h12; rd_addr_i = 7'h40;
    step(); idle();
    chk("R2 same-cycle old value", rd_data_o, 8'h00);
    rbyte(7'h40, d); chk("R2 written value", d, 8'h12);

    // R3 bank mapping table
    foreach (VEC[i]) begin
      pswwr({3'b000, VEC[i][20:19], 3'b000});
      reg_wr_en_i = 1; reg_num_i = VEC[i][18:16]; reg_wdata_i = VEC[i][15:8];
      step(); idle();
      rd_addr_i = VEC[i][6:0]; step();
      chk("R3 byte view", rd_data_o, VEC[i][15:8]);
      chk("R3 reg view", reg_rdata_o, VEC[i][15:8]);
    end

    // R4 R5 status word
    pswwr(8'hFF);
    chk("R4 reserved zero, parity untouched", psw_o, 8'hFC);
    acc_wr_en_i = 1; acc_data_i = 8'h07; step(); idle();
    chk("R5 odd parity", psw_o, 8'hFD);
    pswwr(8'h00);
    chk("R4 parity kept over write", psw_o, 8'h01);
    acc_wr_en_i = 1; acc_data_i = 8'h03; step(); idle();
    chk("R5 even parity", psw_o, 8'h00);

    // R6 R7 bit operations
    wbyte(7'h2C, 8'h00);
    bitop(2'b00, 7'h67, 1'b0);
    rbyte(7'h2C, d); chk("R6 R7 set 67H -> 2CH.7", d, 8'h80);
    bit_addr_i = 7'h67; step();
    chk("R6 bit read", {7'b0, bit_rd_o}, 8'h01);
    wbyte(7'h2C, 8'hFF);
    bitop(2'b01, 7'h60, 1'b0);
    rbyte(7'h2C, d); chk("R7 clear", d, 8'hFE);
    bitop(2'b10, 7'h61, 1'b0);
    rbyte(7'h2C, d); chk("R7 and 0", d, 8'hFC);
    bitop(2'b10, 7'h62, 1'b1);
    rbyte(7'h2C, d); chk("R7 and 1", d, 8'hFC);
    bitop(2'b11, 7'h60, 1'b1);
    rbyte(7'h2C, d); chk("R7 or 1", d, 8'hFD);
    bitop(2'b11, 7'h61, 1'b0);
    rbyte(7'h2C, d); chk("R7 or 0", d, 8'hFD);
    bitop(2'b00, 7'h00, 1'b0);
    rbyte(7'h20, d); chk("R6 low edge", d, 8'h01);
    bitop(2'b00, 7'h7F, 1'b0);
    rbyte(7'h2F, d); chk("R6 high edge", d, 8'h80);

    // R8 stack
    push_i = 1; push_data_i = 8'hA1; step(); idle();
    chk("R8 push sp", {1'b0, sp_o}, 8'h08);
    rbyte(7'h08, d); chk("R8 push lands", d, 8'hA1);
    push_i = 1; push_data_i = 8'hB2; step(); idle();
    pop_i = 1; step(); idle();
    chk("R8 pop data", pop_data_o, 8'hB2);
    chk("R8 pop sp", {1'b0, sp_o}, 8'h08);
    pop_i = 1; step(); idle();
    chk("R8 pop data 2", pop_data_o, 8'hA1);
    push_i = 1; pop_i = 1; push_data_i = 8'hEE; step(); idle();
    chk("R8 both sp", {1'b0, sp_o}, 8'h07);
    chk("R8 both pop data", pop_data_o, 8'hA1);
    rbyte(7'h08, d); chk("R8 both no write", d, 8'hA1);

    // R9 wrap
    for (int k = 0; k < 120; k++) begin
      push_i = 1; push_data_i = 8'h5C; step();
    end
    idle();
    chk("R9 sp at top", {1'b0, sp_o}, 8'h7F);
    push_i = 1; push_data_i = 8'hC3; step(); idle();
    chk("R9 push wrap", {1'b0, sp_o}, 8'h00);
    rbyte(7'h00, d); chk("R9 wrapped byte", d, 8'hC3);
    pop_i = 1; step(); idle();
    chk("R9 pop wrap sp", {1'b0, sp_o}, 8'h7F);
    chk("R9 pop wrap data", pop_data_o, 8'hC3);

    // R10 collisions
    wr_en_i = 1; wr_addr_i = 7'h25; wr_data_i = 8'h00;
    bit_en_i = 1; bit_op_i = 2'b00; bit_addr_i = 7'h2B; step(); idle();
    rbyte(7'h25, d); chk("R10 byte+set", d, 8'h08);
    wr_en_i = 1; wr_addr_i = 7'h25; wr_data_i = 8'hF0;
    bit_en_i = 1; bit_op_i = 2'b01; bit_addr_i = 7'h2C; step(); idle();
    rbyte(7'h25, d); chk("R10 byte+clear", d, 8'hE0);
    wr_en_i = 1; wr_addr_i = 7'h05; wr_data_i = 8'h11;
    reg_wr_en_i = 1; reg_num_i = 3'd5; reg_wdata_i = 8'h22; step(); idle();
    rbyte(7'h05, d); chk("R10 reg over byte", d, 8'h22);
    wr_en_i = 1; wr_addr_i = 7'h00; wr_data_i = 8'h33;
    push_i = 1; push_data_i = 8'h44; step(); idle();
    rbyte(7'h00, d); chk("R10 push over byte", d, 8'h44);

    finish_run();
  end
endmodule